// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This unit gathers interrupt requests from one UART channel and reduces them to a single status byte that the host reads. The requests come from the receiver, the transmitter, the modem-status logic and the flow-control logic. Each request source has its own enable bit. The enabled requests are ranked, and only the most urgent one is encoded into the low six bits of the byte. Bit 0 of the byte is an active-low "nothing pending" flag. The top two bits mirror the FIFO-enable setting. An interrupt line follows the inverse of bit 0.

The host reads the byte and then pulses a read strobe. That strobe retires only the source that the byte was showing, so the next read shows the next most urgent source. Sources of two kinds are handled differently:

- Strobe-type sources (line error, receive timeout, modem change, flow-line change) are latched and stay pending until a read retires them.
- Condition-type sources (receive data available, transmit holding empty) are held back for one read after they are retired, and appear again if their condition still holds.

Two further levels are available only when the enhanced-feature bit is set. The Xoff/special-character flag is not retired by reads. Only an Xon event clears it.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, `stat_o` is 8'h01 and `irq_o` is 0.
- R2: The six-bit codes in `stat_o[5:0]`, ranked from most to least urgent, are:
  - line error: 6'h06
  - receive timeout: 6'h0C
  - receive data available: 6'h04
  - transmit holding empty: 6'h02
  - modem change: 6'h00
  - Xoff/special character: 6'h10
  - flow-line change: 6'h20

  With nothing pending, the code is 6'h01. Only the highest-ranked pending source is shown.
- R3: When receive timeout and receive data available are both pending, the timeout code 6'h0C is shown.
- R4: A cycle with `stat_rd` high retires only the source that `stat_o` was showing in that cycle. The next most urgent pending source then appears.
- R5: A condition-type source that was retired by a read is hidden until the next read. After that read, it shows again if its input is still high.
- R6: The Xoff/special-character flag is set by `xoff_seen_stb` and is not cleared by reads. It is cleared by `xon_seen_stb`, and Xon wins over a same-cycle Xoff. While the flag is set, the flow-line change source cannot be shown.
- R7: When `enh_on` is 0, the Xoff and flow-line strobes are not latched, and `stat_o[5:4]` reads 0.
- R8: `stat_o[7:6]` reads 2'b11 in the cycle after `fifo_on` is 1, and 2'b00 in the cycle after it is 0.
- R9: `src_en` bits, from bit 0 to bit 6, enable these sources in order: line error, timeout, data available, transmit empty, modem change, Xoff, flow-line change. A source whose enable bit is clear is neither latched nor shown.
- R10: `stat_o` and `irq_o` reflect a strobe or a condition one clock edge after it is sampled. `irq_o` is the inverse of `stat_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_err_stb | input | 1 | Receiver line error event |
| rx_timeout_stb | input | 1 | Receive timeout event |
| rx_avail | input | 1 | Receive data available condition |
| tx_empty | input | 1 | Transmit holding register empty condition |
| modem_chg_stb | input | 1 | Modem input change event |
| xoff_seen_stb | input | 1 | Xoff or special character received |
| xon_seen_stb | input | 1 | Xon received, clears the Xoff flag |
| flow_chg_stb | input | 1 | Flow-control line change event |
| src_en | input | 7 | Per-source enable bits |
| fifo_on | input | 1 | FIFO enable setting |
| enh_on | input | 1 | Enhanced-feature enable |
| stat_rd | input | 1 | Host read strobe for the status byte |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions check the following on every cycle:

- the code field always holds one of the eight legal values;
- the enhanced bits stay clear while the feature bit is off;
- the FIFO bits track their setting;
- a fully disabled enable mask yields "nothing pending";
- a line error shows one edge later;
- a read that shows a line error retires it.

Some behaviour can only be shown by the bench scenarios, because it depends on sequences of reads:

- the step-down from one source to the next;
- the hold-back of a condition source for exactly one read and its later return;
- the persistence of the Xoff flag across reads until Xon arrives;
- the timeout taking precedence over data available.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 7;
    localparam int CODE_W  = 6;
    localparam int STAT_W  = 8;

    // Source index doubles as rank: index 0 is most urgent.
    localparam int IDX_LINE  = 0;
    localparam int IDX_TMO   = 1;
    localparam int IDX_AVAIL = 2;
    localparam int IDX_TXE   = 3;
    localparam int IDX_MODEM = 4;
    localparam int IDX_XOFF  = 5;
    localparam int IDX_FLOW  = 6;

    typedef enum logic {SRC_LATCH, SRC_LEVEL} src_kind_e;

    localparam src_kind_e SRC_KIND [NUM_SRC] = '{
        SRC_LATCH, SRC_LATCH, SRC_LEVEL, SRC_LEVEL, SRC_LATCH, SRC_LATCH, SRC_LATCH
    };

    localparam logic [CODE_W-1:0] SRC_CODE [NUM_SRC] = '{
        6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20
    };

    localparam logic [CODE_W-1:0]  NO_IRQ_CODE = 6'h01;
    localparam logic [NUM_SRC-1:0] ENH_ONLY    = NUM_SRC'(1) << IDX_XOFF | NUM_SRC'(1) << IDX_FLOW;
    localparam logic [NUM_SRC-1:0] STICKY      = NUM_SRC'(1) << IDX_XOFF;

    typedef struct packed {
        logic [STAT_W-1:0]  status;
        logic [NUM_SRC-1:0] rep;
    } irq_state_t;

    function automatic logic [CODE_W-1:0] code_of(input logic [NUM_SRC-1:0] grant);
        code_of = NO_IRQ_CODE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) code_of = SRC_CODE[i];
        end
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import uart_irq_pkg::*;
#(
    parameter src_kind_e KIND = SRC_LATCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,    // enabled strobe (latch) or enabled condition (level)
    input  logic rd_i,     // host read strobe
    input  logic sel_i,    // this source is the one being shown
    input  logic drop_i,   // forced clear (Xon for the sticky flag)
    output logic pend_o    // next-cycle pending state
);

    logic state_d, state_q;

    generate
        if (KIND == SRC_LEVEL) begin : g_level
            // state holds the "hidden for one read" mark
            always_comb begin
                state_d = rd_i ? sel_i : state_q;
                pend_o  = hit_i & ~state_d & ~drop_i;
            end
        end else begin : g_latch
            // state holds the latched request; a same-cycle strobe wins over a read
            always_comb begin
                state_d = ((state_q & ~(rd_i & sel_i)) | hit_i) & ~drop_i;
                pend_o  = state_d;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 7
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    logic [N-1:0] seen;

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_rank
            if (gi == 0) begin : g_first
                assign seen[gi] = 1'b0;
            end else begin : g_rest
                assign seen[gi] = seen[gi-1] | req_i[gi-1];
            end
            assign grant_o[gi] = req_i[gi] & ~seen[gi];
        end
    endgenerate

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_err_stb,
    input  logic               rx_timeout_stb,
    input  logic               rx_avail,
    input  logic               tx_empty,
    input  logic               modem_chg_stb,
    input  logic               xoff_seen_stb,
    input  logic               xon_seen_stb,
    input  logic               flow_chg_stb,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               fifo_on,
    input  logic               enh_on,
    input  logic               stat_rd,
    output logic [STAT_W-1:0]  stat_o,
    output logic               irq_o
);

    irq_state_t         st_d, st_q;
    logic [NUM_SRC-1:0] raw, hit, sel, drop, pend, eff, grant;
    logic [NUM_SRC-1:0] enh_gate;

    assign enh_gate = enh_on ? {NUM_SRC{1'b1}} : ~ENH_ONLY;

    always_comb begin
        raw            = '0;
        raw[IDX_LINE]  = line_err_stb;
        raw[IDX_TMO]   = rx_timeout_stb;
        raw[IDX_AVAIL] = rx_avail;
        raw[IDX_TXE]   = tx_empty;
        raw[IDX_MODEM] = modem_chg_stb;
        raw[IDX_XOFF]  = xoff_seen_stb;
        raw[IDX_FLOW]  = flow_chg_stb;
    end

    assign hit  = raw & src_en & enh_gate;
    assign sel  = st_q.rep & ~STICKY;                        // sticky flag ignores reads
    assign drop = xon_seen_stb ? STICKY : {NUM_SRC{1'b0}};

    generate
        for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
            irq_src_cell #(.KIND(SRC_KIND[gi])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .hit_i  (hit[gi]),
                .rd_i   (stat_rd),
                .sel_i  (sel[gi]),
                .drop_i (drop[gi]),
                .pend_o (pend[gi])
            );
        end
    endgenerate

    assign eff = pend & src_en & enh_gate;

    irq_prio_enc #(.N(NUM_SRC)) u_prio (
        .req_i   (eff),
        .grant_o (grant)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rep    = grant;
        st_d.status = {{(STAT_W-CODE_W){fifo_on}}, code_of(grant)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= {{(STAT_W-CODE_W){1'b0}}, NO_IRQ_CODE};
            st_q.rep    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.status;
    assign irq_o  = ~st_q.status[0];

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
    import uart_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               line_err_stb,
    input logic [NUM_SRC-1:0] src_en,
    input logic               fifo_on,
    input logic               enh_on,
    input logic               stat_rd,
    input logic [STAT_W-1:0]  stat_o
);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[5:0] inside {6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20, 6'h01});

    assert_read_retires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(stat_rd) && $past(stat_o[5:0]) == 6'h06 && !$past(line_err_stb)
        |-> stat_o[5:0] != 6'h06);

    assert_enh_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(enh_on) |-> stat_o[5:4] == 2'b00);

    assert_fifo_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> stat_o[7:6] == {2{$past(fifo_on)}});

    assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(src_en) == '0 |-> stat_o[5:0] == 6'h01);

    assert_line_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(line_err_stb) && $past(src_en[0]) |-> stat_o[5:0] == 6'h06);

endmodule

bind uart_irq_status uart_irq_status_chk u_chk (.*);

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_err_stb, rx_timeout_stb, rx_avail, tx_empty, modem_chg_stb;
    logic       xoff_seen_stb, xon_seen_stb, flow_chg_stb;
    logic [6:0] src_en;
    logic       fifo_on, enh_on, stat_rd;
    logic [7:0] stat_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uart_irq_status dut (
        .clk(clk), .rst_n(rst_n),
        .line_err_stb(line_err_stb), .rx_timeout_stb(rx_timeout_stb),
        .rx_avail(rx_avail), .tx_empty(tx_empty), .modem_chg_stb(modem_chg_stb),
        .xoff_seen_stb(xoff_seen_stb), .xon_seen_stb(xon_seen_stb),
        .flow_chg_stb(flow_chg_stb), .src_en(src_en), .fifo_on(fifo_on),
        .enh_on(enh_on), .stat_rd(stat_rd), .stat_o(stat_o), .irq_o(irq_o)
    );

    // {expected status[7:0], src_en[6:0],
    //  enh, fifo, rd, flow, xon, xoff, modem, txe, avail, tmo, line}
    localparam int NV = 19;
    localparam logic [25:0] VEC [NV] = '{
        {8'hC1, 7'h7F, 11'b110_0000_0000},  // 0  idle, FIFO bits set (R8)
        {8'hC6, 7'h7F, 11'b110_0001_0001},  // 1  line+modem, line wins (R2, R10)
        {8'hC0, 7'h7F, 11'b111_0000_0000},  // 2  read retires line, modem shows (R4)
        {8'hC1, 7'h7F, 11'b111_0000_0000},  // 3  read retires modem (R4)
        {8'hCC, 7'h7F, 11'b110_0000_0110},  // 4  timeout over data available (R3)
        {8'hC4, 7'h7F, 11'b111_0000_0100},  // 5  read retires timeout (R4)
        {8'hC1, 7'h7F, 11'b111_0000_0100},  // 6  data available hidden for one read (R5)
        {8'hC4, 7'h7F, 11'b111_0000_0100},  // 7  returns after next read (R5)
        {8'hC2, 7'h7F, 11'b110_0000_1000},  // 8  transmit empty (R2)
        {8'hD0, 7'h7F, 11'b110_0010_0000},  // 9  Xoff flag (R6)
        {8'hD0, 7'h7F, 11'b111_1000_0000},  // 10 read keeps Xoff, flow waits (R6)
        {8'hE0, 7'h7F, 11'b110_0100_0000},  // 11 Xon clears, flow shows (R6)
        {8'hC1, 7'h7F, 11'b111_0000_0000},  // 12 read retires flow (R4)
        {8'hC1, 7'h7F, 11'b010_1010_0000},  // 13 enhanced off: ignored (R7)
        {8'hC1, 7'h7F, 11'b110_0000_0000},  // 14 nothing was latched (R7)
        {8'h00, 7'h7F, 11'b100_0001_0000},  // 15 FIFO off, modem shows (R8)
        {8'h01, 7'h7F, 11'b101_0000_0000},  // 16 read retires modem (R4)
        {8'h01, 7'h00, 11'b100_0000_0001},  // 17 masked line error (R9)
        {8'h01, 7'h7F, 11'b100_0000_0000}   // 18 it was not latched (R9)
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [17:0] v);
        {src_en, enh_on, fifo_on, stat_rd, flow_chg_stb, xon_seen_stb, xoff_seen_stb,
         modem_chg_stb, tx_empty, rx_avail, rx_timeout_stb, line_err_stb} = v;
    endtask

    initial begin
        drive(18'h0);
        src_en = 7'h7F;
        #20;
        check("R1 reset status", stat_o, 8'h01);
        check("R1 reset irq", {7'b0, irq_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][17:0]);
            @(posedge clk);
            #1;
            check($sformatf("R2/R10 vector %0d status", i), stat_o, VEC[i][25:18]);
            check($sformatf("R10 vector %0d irq", i), {7'b0, irq_o}, {7'b0, ~VEC[i][18]});
        end

        // Xon and Xoff in the same cycle: Xon wins (R6)
        @(negedge clk);
        drive({7'h7F, 11'b110_0110_0000});
        @(posedge clk); #1;
        check("R6 xon wins", stat_o, 8'hC1);

        // Pending line error wiped by mid-run reset (R1)
        @(negedge clk);
        drive({7'h7F, 11'b110_0000_0001});
        @(posedge clk); #1;
        check("R2 line pending", stat_o, 8'hC6);
        @(negedge clk);
        drive({7'h7F, 11'b110_0000_0000});
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", stat_o, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 stays clear after reset", stat_o, 8'hC1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule